// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable static memory with a pipelined read path. Each word is split into byte lanes of nine bits: eight data bits plus one parity bit. The address, the write data, the three chip selects, the burst controls and the write enables are all captured on the rising clock edge. A read returns its word through one output register, so the data appears on the bus one clock after the read is captured.

A burst begins with either of two start strobes. The processor-side strobe has priority, and its cycle is always a read. The controller-side strobe may read or write. Each later cycle of the burst takes its address from a two-bit counter, which steps only when the advance input is low. That counter folds into the low address bits in linear order or in interleaved order.

A write is committed to the array in the cycle after it is captured. One lane-enable bit selects each lane, and a global write forces all lanes to be written. The output enable gates the output drivers directly, with no clock. Deselecting the block takes the bus out of drive one clock later. The data bus is brought out as a separate input, output and output-enable so that it fits on-chip wiring. A pad tristate is built from these three signals.

Top module: `pipe_burst_sram`

## Requirements
- R1: A start strobe selects the block only when sel_a_n=0, sel_b=1 and sel_c_n=0. With any other combination, the strobe performs no write, starts no burst, and leaves dq_oe low.
- R2: A read captured at clock edge N drives dq_o with the addressed word after edge N+1, with dq_oe high while oe_n is low.
- R3: When all_wr_n=1, lane i is written only if byte_wr_n=0 and lane_we_n[i]=0. Lane i occupies dq bits 9i+8..9i, and its parity bit is bit 9i+8. Lanes not enabled keep their old contents.
- R4: all_wr_n=0 writes all four lanes, whatever the values of byte_wr_n and lane_we_n.
- R5: oe_n=1 forces dq_oe low at once, with no clock edge. Returning oe_n to 0 restores drive of the held word.
- R6: A deselect cycle captured right after a read drops dq_oe after the next clock edge.
- R7: During the cycle after a captured write, dq_oe is low.
- R8: With burst_linear=1, a burst that starts at address A steps its two low bits as A+0, A+1, A+2, A+3 modulo 4. The upper bits do not change.
- R9: With burst_linear=0, the two low bits of the burst follow A xor 0, A xor 1, A xor 2, A xor 3.
- R10: A cycle with no strobe and adv_n=1 inside a burst repeats the previous address.
- R11: A read of an address, captured in the cycle right after a write to that address, returns the new data.
- R12: A cycle with start_p_n=0 is a read even when start_c_n=0 and the write enables are asserted. It stores nothing.
- R13: Reset, which is synchronous with rst_n=0, leaves dq_oe low and ends any burst. Cycles with no strobe after reset stay deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| start_p_n | input | 1 | Processor-side burst start, read only |
| start_c_n | input | 1 | Controller-side burst start |
| adv_n | input | 1 | Burst advance, active low |
| burst_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| byte_wr_n | input | 1 | Qualifier for the per-lane enables, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LW | Write data from the bus |
| dq_o | output | LANES*LW | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after the timing edges of the bus:
- A design with one pipeline register too many or too few puts the word one cycle off, where a single-edge sample misses it.
- A deselect or a write that does not release the bus leaves dq_oe high for an extra cycle.
- An output enable that waits for the clock stays high after oe_n rises.

It also targets the address and write corner cases:
- Burst order is checked from a start address in mid-group, so that a design mixing up linear and interleaved order, or carrying out of the two-bit group, reads the wrong word.
- Lane masks that leave the parity lane or the lane qualifier unchanged catch designs that write too much.
- A read right behind a write catches a commit that is late.
- A strobe with a bad select pattern or a doubled strobe catches loose decode.

// File: rtl/pbs_pkg.sv
// Shared types for the pipelined burst SRAM.
// Assumes a burst counter two bits wide, so bursts cover four words.
package pbs_pkg;
    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits of one burst step, in linear or interleaved order.
    function automatic logic [BURST_BITS-1:0] burst_low(
        input logic [BURST_BITS-1:0] base,
        input logic [BURST_BITS-1:0] step,
        input logic                  linear
    );
        return linear ? (base + step) : (base ^ step);
    endfunction
endpackage

// File: rtl/pbs_ctrl.sv
// Cycle controller: decodes the selects, the strobes and the write enables.
// Runs the burst counter and captures one cycle's address, op, mask and data.
// Assumes that AW is at least BURST_BITS + 1.
module pbs_ctrl
    import pbs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                start_p_n,
    input  logic                start_c_n,
    input  logic                adv_n,
    input  logic                burst_linear,
    input  logic [LANES-1:0]    lane_we_n,
    input  logic                byte_wr_n,
    input  logic                all_wr_n,
    input  logic [LANES*LW-1:0] din,
    output op_e                 op_q,
    output logic [AW-1:0]       addr_q,
    output logic [LANES-1:0]    mask_q,
    output logic [LANES*LW-1:0] wdata_q
);
    localparam int UPPER = AW - BURST_BITS;

    logic                  sel_ok, strobe;
    logic [LANES-1:0]      wr_mask;
    logic [AW-1:0]         base_q, nxt_base, nxt_addr;
    logic [BURST_BITS-1:0] cnt_q, nxt_cnt;
    logic                  active_q, nxt_active;
    logic [LANES-1:0]      nxt_mask;
    op_e                   nxt_op;

    // Decode of the three selects, the strobes and the lane write mask.
    always_comb begin
        sel_ok  = !sel_a_n && sel_b && !sel_c_n;
        strobe  = !start_p_n || !start_c_n;
        wr_mask = !all_wr_n ? '1 : (!byte_wr_n ? ~lane_we_n : '0);
    end

    // Next cycle: a burst start, a burst continuation or a deselect.
    always_comb begin
        nxt_op     = OP_DESEL;
        nxt_addr   = addr_q;
        nxt_base   = base_q;
        nxt_cnt    = cnt_q;
        nxt_active = active_q;
        nxt_mask   = '0;
        if (strobe) begin
            if (sel_ok) begin
                nxt_active = 1'b1;
                nxt_base   = addr;
                nxt_cnt    = '0;
                nxt_addr   = addr;
                if (!start_p_n) begin
                    nxt_op = OP_READ;
                end else begin
                    nxt_mask = wr_mask;
                    nxt_op   = (|wr_mask) ? OP_WRITE : OP_READ;
                end
            end else begin
                nxt_active = 1'b0;
            end
        end else if (active_q) begin
            nxt_cnt  = adv_n ? cnt_q : cnt_q + BURST_BITS'(1);
            nxt_addr = {base_q[AW-1:BURST_BITS],
                        burst_low(base_q[BURST_BITS-1:0], nxt_cnt, burst_linear)};
            nxt_mask = wr_mask;
            nxt_op   = (|wr_mask) ? OP_WRITE : OP_READ;
        end
    end

    // Capture registers for the cycle and the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_DESEL;
            addr_q   <= '0;
            mask_q   <= '0;
            wdata_q  <= '0;
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            op_q     <= nxt_op;
            addr_q   <= nxt_addr;
            mask_q   <= nxt_mask;
            base_q   <= nxt_base;
            cnt_q    <= nxt_cnt;
            active_q <= nxt_active;
            if (nxt_op == OP_WRITE) begin
                wdata_q <= din;
            end
        end
    end

    assert_bad_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel_ok) |=> (op_q == OP_DESEL));

    assert_global_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p_n && !start_c_n && sel_ok && !all_wr_n) |=> (op_q == OP_WRITE && &mask_q));

    assert_proc_start_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_p_n && sel_ok) |=> (op_q == OP_READ && mask_q == '0));

    assert_hold_address_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p_n && start_c_n && active_q && adv_n) |=> $stable(addr_q));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p_n && start_c_n && active_q) |=> $stable(addr_q[AW-1:AW-UPPER]));
endmodule

// File: rtl/pbs_array.sv
// Storage array with per-lane write commit. Reads are combinational from the captured address.
// Assumes that the contents are not reset: writes take place only on captured write cycles.
module pbs_array #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                wr_i,
    input  logic [AW-1:0]       waddr_i,
    input  logic [LANES-1:0]    mask_i,
    input  logic [LANES*LW-1:0] wdata_i,
    input  logic [AW-1:0]       raddr_i,
    output logic [LANES*LW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LW;

    logic [DW-1:0] mem [DEPTH];

    // Commit each enabled lane of the captured write.
    always_ff @(posedge clk) begin
        if (wr_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask_i[l]) begin
                    mem[waddr_i][l*LW +: LW] <= wdata_i[l*LW +: LW];
                end
            end
        end
    end

    // Array read port.
    always_comb rdata_o = mem[raddr_i];
endmodule

// File: rtl/pbs_outreg.sv
// Output pipeline register and drive enable.
// Assumes that only a captured read loads the register; any other cycle releases the bus one clock later.
module pbs_outreg
    import pbs_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          oe_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);
    logic valid_q;

    // Load the read word and record whether it may be driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            dq_o    <= '0;
        end else begin
            valid_q <= (op_i == OP_READ);
            if (op_i == OP_READ) begin
                dq_o <= rdata_i;
            end
        end
    end

    // The output enable gates the drivers directly, with no clock.
    always_comb dq_oe = valid_q && !oe_n;

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_READ) |=> valid_q);

    assert_write_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WRITE) |=> !valid_q);

    assert_deselect_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DESEL) |=> !valid_q);
endmodule

// File: rtl/pipe_burst_sram.sv
// Top of the pipelined burst SRAM: controller, array and output stage.
// Assumes that a pad tristate is built outside from dq_o and dq_oe.
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                start_p_n,
    input  logic                start_c_n,
    input  logic                adv_n,
    input  logic                burst_linear,
    input  logic [LANES-1:0]    lane_we_n,
    input  logic                byte_wr_n,
    input  logic                all_wr_n,
    input  logic                oe_n,
    input  logic [LANES*LW-1:0] dq_i,
    output logic [LANES*LW-1:0] dq_o,
    output logic                dq_oe
);
    localparam int DW = LANES * LW;

    op_e              op_q;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] mask_q;
    logic [DW-1:0]    wdata_q, rdata;

    pbs_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .start_p_n(start_p_n), .start_c_n(start_c_n), .adv_n(adv_n),
        .burst_linear(burst_linear), .lane_we_n(lane_we_n),
        .byte_wr_n(byte_wr_n), .all_wr_n(all_wr_n), .din(dq_i),
        .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q), .wdata_q(wdata_q)
    );

    pbs_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk(clk), .wr_i(op_q == OP_WRITE), .waddr_i(addr_q),
        .mask_i(mask_q), .wdata_i(wdata_q), .raddr_i(addr_q), .rdata_o(rdata)
    );

    pbs_outreg #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .op_i(op_q), .rdata_i(rdata),
        .oe_n(oe_n), .dq_o(dq_o), .dq_oe(dq_oe)
    );
endmodule

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          start_p_n = 1'b1, start_c_n = 1'b1, adv_n = 1'b1;
    logic          burst_linear = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          byte_wr_n = 1'b1, all_wr_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] model [64];

    always #4 clk = ~clk;

    pipe_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .start_p_n(start_p_n), .start_c_n(start_c_n),
        .adv_n(adv_n), .burst_linear(burst_linear), .lane_we_n(lane_we_n),
        .byte_wr_n(byte_wr_n), .all_wr_n(all_wr_n), .oe_n(oe_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // Fields: addr[47:42], all_wr_n[41], byte_wr_n[40], lane_we_n[39:36], data[35:0]
    localparam logic [47:0] VEC [8] = '{
        {6'd5,  1'b0, 1'b1, 4'b1111, 36'hA_1234_5678},
        {6'd5,  1'b1, 1'b0, 4'b1110, 36'h1_FFFF_F0EE},
        {6'd5,  1'b1, 1'b0, 4'b0101, 36'hF_0BAD_C0DE},
        {6'd9,  1'b1, 1'b1, 4'b0000, 36'h3_3333_3333},
        {6'd9,  1'b0, 1'b0, 4'b0000, 36'h6_5A5A_A5A5},
        {6'd33, 1'b1, 1'b0, 4'b0111, 36'hF_F000_0000},
        {6'd63, 1'b0, 1'b1, 4'b1010, 36'h0_0FED_CBA9},
        {6'd0,  1'b1, 1'b0, 4'b0000, 36'hE_DCBA_9876}
    };

    function automatic logic [DW-1:0] word_of(input int a);
        return 36'h8_0000_0000 ^ (36'(a) * 36'h0_0102_0409) ^ 36'(a);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        start_p_n = 1'b1; start_c_n = 1'b1; adv_n = 1'b1;
        lane_we_n = 4'hF; byte_wr_n = 1'b1; all_wr_n = 1'b1;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic desel();
        quiet(); sel_a_n = 1'b1; start_c_n = 1'b0; tick();
    endtask

    task automatic start_rd(input int a);
        quiet(); addr = AW'(a); start_c_n = 1'b0; tick();
    endtask

    task automatic start_wr(input int a, input logic gw, input logic bwe,
                            input logic [3:0] ln, input logic [DW-1:0] d);
        quiet(); addr = AW'(a); start_c_n = 1'b0;
        all_wr_n = gw; byte_wr_n = bwe; lane_we_n = ln; dq_i = d; tick();
        for (int l = 0; l < 4; l++) begin
            if (!gw || (!bwe && !ln[l])) model[a][l*9 +: 9] = d[l*9 +: 9];
        end
    endtask

    task automatic cont(input logic adv);
        quiet(); adv_n = adv; tick();
    endtask

    task automatic rd_check(input int a, input string req);
        start_rd(a);
        desel();
        check(req, {35'd0, dq_oe}, 36'd1);
        check(req, dq_o, model[a]);
        desel();
        check("R6", {35'd0, dq_oe}, 36'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet();
        repeat (3) tick();
        rst_n = 1'b1;
        check("R13", {35'd0, dq_oe}, 36'd0);
        cont(1'b0); cont(1'b0);
        check("R13", {35'd0, dq_oe}, 36'd0);

        for (int a = 0; a < 64; a++) begin
            start_wr(a, 1'b0, 1'b1, 4'hF, word_of(a));
        end
        desel();

        // Table walk: lane writes (R3) and global writes (R4), each read back.
        for (int i = 0; i < 8; i++) begin
            start_wr(int'(VEC[i][47:42]), VEC[i][41], VEC[i][40], VEC[i][39:36], VEC[i][35:0]);
            desel();
            rd_check(int'(VEC[i][47:42]), VEC[i][41] ? "R3" : "R4");
        end

        // R2: the word appears exactly one clock after the read is captured.
        start_rd(12);
        check("R2", {35'd0, dq_oe}, 36'd0);
        desel();
        check("R2", dq_o, model[12]);

        // R5: the output enable acts without a clock.
        oe_n = 1'b1; #1;
        check("R5", {35'd0, dq_oe}, 36'd0);
        oe_n = 1'b0; #1;
        check("R5", {35'd0, dq_oe}, 36'd1);
        desel();

        // R11: read directly behind a write to the same address.
        start_wr(20, 1'b0, 1'b1, 4'hF, 36'h7_1357_9BDF);
        start_rd(20);
        desel();
        check("R11", dq_o, 36'h7_1357_9BDF);
        desel();

        // R7: a captured write releases the bus in the next cycle.
        start_rd(21);
        start_wr(21, 1'b0, 1'b1, 4'hF, 36'h2_4680_ACE1);
        check("R7", {35'd0, dq_oe}, 36'd1);
        desel();
        check("R7", {35'd0, dq_oe}, 36'd0);
        rd_check(21, "R7");

        // R12: both strobes, with a global write asserted, make a plain read.
        quiet(); addr = 6'd41; start_p_n = 1'b0; start_c_n = 1'b0;
        all_wr_n = 1'b0; dq_i = 36'hD_EADB_EEF0; tick();
        desel();
        check("R12", dq_o, model[41]);
        desel();
        rd_check(41, "R12");

        // R1: each bad select pattern neither writes nor starts a burst.
        for (int p = 0; p < 3; p++) begin
            quiet(); addr = 6'd5; start_c_n = 1'b0; all_wr_n = 1'b0; dq_i = 36'h0_DEAD_0000;
            if (p == 0) sel_a_n = 1'b1;
            if (p == 1) sel_b = 1'b0;
            if (p == 2) sel_c_n = 1'b1;
            tick();
            cont(1'b1); cont(1'b1);
            check("R1", {35'd0, dq_oe}, 36'd0);
            rd_check(5, "R1");
        end

        // R8: linear burst that starts at 18 gives 18, 19, 16, 17.
        burst_linear = 1'b1;
        start_rd(18);
        for (int j = 0; j < 4; j++) begin
            if (j < 3) cont(1'b0); else desel();
            check("R8", dq_o, model[{4'd4, 2'(2 + j)}]);
        end
        desel();

        // R9: interleaved burst that starts at 17 gives 17, 16, 19, 18.
        burst_linear = 1'b0;
        start_rd(17);
        for (int j = 0; j < 4; j++) begin
            if (j < 3) cont(1'b0); else desel();
            check("R9", dq_o, model[{4'd4, 2'(1 ^ j)}]);
        end
        desel();
        burst_linear = 1'b1;

        // R10: a burst with no advance repeats its address.
        start_rd(40);
        cont(1'b1);
        check("R10", dq_o, model[40]);
        cont(1'b1);
        check("R10", dq_o, model[40]);
        desel();
        check("R10", dq_o, model[40]);
        desel();

        // R13: a reset in mid-burst ends the burst.
        start_rd(16);
        rst_n = 1'b0;
        cont(1'b0);
        rst_n = 1'b1;
        check("R13", {35'd0, dq_oe}, 36'd0);
        cont(1'b0);
        check("R13", {35'd0, dq_oe}, 36'd0);
        cont(1'b0);
        check("R13", {35'd0, dq_oe}, 36'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule